// File: doc/BRIEF.md
# Serial Control Register Interface

This block is the write-only control port of an audio rate-conversion datapath. A host drives three wires: a data line, a serial clock and a latch enable. Each rising serial-clock edge moves one bit into a 12-bit serial-to-parallel register. On the rising edge of the latch enable, the oldest of the twelve held bits picks the destination. A zero sends the other eleven bits to the attenuation target register. A one sends them to the mode-flag register, which holds the test bits, a rate-measurement mode bit, a +12 dB gain flag, two de-emphasis sample-rate select bits and a de-emphasis enable.

A mode input picks where the de-emphasis controls come from. When it is high they come from the registers. When it is low they come from three external pins, and the attenuation output is held at unity. Any change in the effective de-emphasis sample rate raises a mute request. The request holds for a fixed number of output words, which are counted on a word strobe, so that the downstream filter can settle. All three serial wires and the control pins are resynchronized into the system clock before use, and the serial edges are detected in that domain.

Top module: `sctl_port`

## Requirements
- R1: After reset, with host_mode high, atten_target reads 0x400, test_bits, rate_meas_mode, gain_boost and deemph_en read 0, deemph_fs reads 0 (44.1 kHz), and mute_req is low.
- R2: A latched frame whose first-shifted bit is 0 loads its following 11 bits into atten_target, MSB first, and leaves every mode flag unchanged.
- R3: A latched frame whose first-shifted bit is 1 loads the mode flags. Bits 2 to 7 go to test_bits, with bit 2 as test_bits[5]. Bit 8 goes to rate_meas_mode, bit 9 to gain_boost, bits 10 and 11 are the rate pair (b1, b2), and bit 12 goes to deemph_en. atten_target is left unchanged.
- R4: Only the last 12 bits shifted before the latch edge form the frame. Earlier bits are discarded.
- R5: Shifting bits with no latch rising edge changes no output. A latch edge on its own, without further shifting, commits the 12 bits already held.
- R6: The rate pair (b1, b2) decodes onto deemph_fs as follows: 00 or 01 give 0 (44.1 kHz), 10 gives 1 (48 kHz) and 11 gives 2 (32 kHz).
- R7: With host_mode low, deemph_en follows pin_deemph_en and deemph_fs is decoded from (pin_rate_b1, pin_rate_b2). atten_target reads 0x400, and test_bits, rate_meas_mode and gain_boost read 0. Frames still latch into the registers, and their contents show again once host_mode returns high.
- R8: A change of the decoded effective rate raises mute_req on the next clock. mute_req then stays high for exactly HOLD_WORDS (default 3072) word_tick pulses and falls on the last of them, so the following word is unmuted.
- R9: A further rate change while mute_req is high restarts the full HOLD_WORDS count.
- R10: Toggling deemph_en, or moving the rate pair between 00 and 01, does not raise mute_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 selects the registers for de-emphasis control, 0 selects the pins |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, first bit is the routing bit |
| ser_lat | input | 1 | Latch enable; its rising edge commits the frame |
| pin_deemph_en | input | 1 | De-emphasis enable used when host_mode is low |
| pin_rate_b1 | input | 1 | Rate select bit 1 used when host_mode is low |
| pin_rate_b2 | input | 1 | Rate select bit 2 used when host_mode is low |
| word_tick | input | 1 | One-cycle strobe per output word |
| atten_target | output | 11 | Attenuation target, 0x400 is unity |
| test_bits | output | 6 | Test flags from frame bits 2 to 7 |
| rate_meas_mode | output | 1 | Rate-measurement mode flag |
| gain_boost | output | 1 | +12 dB gain flag |
| deemph_en | output | 1 | Effective de-emphasis enable |
| deemph_fs | output | 2 | Effective de-emphasis rate: 0 = 44.1, 1 = 48, 2 = 32 kHz |
| mute_req | output | 1 | Mute request during the settle hold-off |

## Verification
A serial clock or latch edge passes through two synchronizer stages and one edge-detect register. The register outputs therefore move on the third system-clock edge after the pin changes, and mute_req moves one edge after that. The pin-mode inputs reach the outputs two edges after a change, and mute_req follows one edge later. mute_req falls on the same edge that samples the final word_tick. The bench holds each serial level for four cycles and waits ten cycles after each latch pulse. It changes inputs and samples outputs on falling clock edges. It counts hold-off words exactly, checking just before and just after the last one.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam int FRAME_BITS = 12;
  localparam int FLAG_BITS  = FRAME_BITS - 1;
  localparam int TEST_BITS  = 6;

  typedef enum logic [1:0] {
    FS_44K1 = 2'd0,
    FS_48K  = 2'd1,
    FS_32K  = 2'd2
  } fs_sel_e;

  // field order follows the order in which the bits arrive after the routing bit
  typedef struct packed {
    logic [TEST_BITS-1:0] test;
    logic                 meas;
    logic                 boost;
    logic                 rate_b1;
    logic                 rate_b2;
    logic                 en;
  } mode_flags_t;

  function automatic fs_sel_e fs_decode(input logic b1, input logic b2);
    case ({b1, b2})
      2'b10:   return FS_48K;
      2'b11:   return FS_32K;
      default: return FS_44K1;
    endcase
  endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      if (STAGES > 1) chain_d = {chain_q[STAGES-2:0], async_in[i]};
      else            chain_d = async_in[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign sync_out[i] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
  import sctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_lvl,
  input  logic                 lat_lvl,
  input  logic                 dat_lvl,
  output logic [FLAG_BITS-1:0] atten_q,
  output mode_flags_t          flags_q
);

  localparam logic [FLAG_BITS-1:0] ATT_RESET = FLAG_BITS'(1) << (FLAG_BITS - 1);

  logic                  sclk_prev_q, lat_prev_q;
  logic                  sclk_rise, lat_rise;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [FLAG_BITS-1:0]  atten_d;
  mode_flags_t           flags_d;

  always_comb begin
    sclk_rise = sclk_lvl & ~sclk_prev_q;
    lat_rise  = lat_lvl & ~lat_prev_q;

    sr_d = sr_q;
    if (sclk_rise) sr_d = {sr_q[FRAME_BITS-2:0], dat_lvl};

    atten_d = atten_q;
    flags_d = flags_q;
    if (lat_rise) begin
      if (sr_q[FRAME_BITS-1]) flags_d = mode_flags_t'(sr_q[FLAG_BITS-1:0]);
      else                    atten_d = sr_q[FLAG_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      lat_prev_q  <= 1'b0;
      sr_q        <= '0;
      atten_q     <= ATT_RESET;
      flags_q     <= '0;
    end else begin
      sclk_prev_q <= sclk_lvl;
      lat_prev_q  <= lat_lvl;
      sr_q        <= sr_d;
      atten_q     <= atten_d;
      flags_q     <= flags_d;
    end
  end

  // R5: registers only move on a latch edge
  p_hold_no_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rise |=> ($stable(atten_q) && $stable(flags_q)));

  // R2: attenuation frames leave the mode flags alone
  p_route_atten_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && !sr_q[FRAME_BITS-1]) |=> $stable(flags_q));

  // R3: mode frames leave the attenuation target alone
  p_route_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && sr_q[FRAME_BITS-1]) |=> $stable(atten_q));

endmodule

// File: rtl/sctl_mute.sv
module sctl_mute
  import sctl_pkg::*;
#(
  parameter int HOLD_WORDS = 3072
) (
  input  logic    clk,
  input  logic    rst_n,
  input  fs_sel_e fs_in,
  input  logic    word_tick,
  output logic    mute_q
);

  localparam int               CNT_W  = $clog2(HOLD_WORDS + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_WORDS);

  fs_sel_e          rate_q;
  logic             primed_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mute_d;
  logic             change;

  always_comb begin
    change = primed_q && (fs_in != rate_q);
    mute_d = mute_q;
    cnt_d  = cnt_q;
    if (change) begin
      mute_d = 1'b1;
      cnt_d  = HOLD_V;
    end else if (mute_q && word_tick) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) mute_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q   <= FS_44K1;
      primed_q <= 1'b0;
      mute_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      rate_q   <= fs_in;
      primed_q <= 1'b1;
      mute_q   <= mute_d;
      cnt_q    <= cnt_d;
    end
  end

  // R8: a rate change loads the full hold-off and mutes
  p_mute_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    change |=> (mute_q && cnt_q == HOLD_V));

  // R8: without a word strobe the hold-off does not advance
  p_mute_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_q && !word_tick && !change) |=> (mute_q && $stable(cnt_q)));

  // R8: release only happens on a word strobe
  p_mute_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_q) |-> $past(word_tick));

  // R9: a change inside the hold-off restarts it
  p_mute_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_q && change) |=> (cnt_q == HOLD_V));

  // R10: without a rate change an idle mute stays idle
  p_mute_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute_q && !change) |=> !mute_q);

endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int HOLD_WORDS  = 3072,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_mode,
  input  logic                 ser_clk,
  input  logic                 ser_dat,
  input  logic                 ser_lat,
  input  logic                 pin_deemph_en,
  input  logic                 pin_rate_b1,
  input  logic                 pin_rate_b2,
  input  logic                 word_tick,
  output logic [FLAG_BITS-1:0] atten_target,
  output logic [TEST_BITS-1:0] test_bits,
  output logic                 rate_meas_mode,
  output logic                 gain_boost,
  output logic                 deemph_en,
  output logic [1:0]           deemph_fs,
  output logic                 mute_req
);

  localparam int                   N_SYNC    = 7;
  localparam logic [FLAG_BITS-1:0] ATT_UNITY = FLAG_BITS'(1) << (FLAG_BITS - 1);

  logic [1:0]           rst_pipe_q;
  logic                 rst_core_n;
  logic [N_SYNC-1:0]    raw_in, sync_in;
  logic                 host_s, sclk_s, dat_s, lat_s, pin_en_s, pin_b1_s, pin_b2_s;
  logic [FLAG_BITS-1:0] atten_q;
  mode_flags_t          flags_q;
  fs_sel_e              eff_fs;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign raw_in = {host_mode, ser_clk, ser_dat, ser_lat, pin_deemph_en, pin_rate_b1, pin_rate_b2};

  sctl_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (raw_in),
    .sync_out (sync_in)
  );

  assign {host_s, sclk_s, dat_s, lat_s, pin_en_s, pin_b1_s, pin_b2_s} = sync_in;

  sctl_regs i_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sclk_lvl (sclk_s),
    .lat_lvl  (lat_s),
    .dat_lvl  (dat_s),
    .atten_q  (atten_q),
    .flags_q  (flags_q)
  );

  always_comb begin
    if (host_s) begin
      eff_fs         = fs_decode(flags_q.rate_b1, flags_q.rate_b2);
      deemph_en      = flags_q.en;
      atten_target   = atten_q;
      test_bits      = flags_q.test;
      rate_meas_mode = flags_q.meas;
      gain_boost     = flags_q.boost;
    end else begin
      eff_fs         = fs_decode(pin_b1_s, pin_b2_s);
      deemph_en      = pin_en_s;
      atten_target   = ATT_UNITY;
      test_bits      = '0;
      rate_meas_mode = 1'b0;
      gain_boost     = 1'b0;
    end
  end

  assign deemph_fs = eff_fs;

  sctl_mute #(.HOLD_WORDS(HOLD_WORDS)) i_mute (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .fs_in     (eff_fs),
    .word_tick (word_tick),
    .mute_q    (mute_req)
  );

  // R6: the decoded rate never takes the unused code
  p_fs_legal_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    deemph_fs != 2'd3);

endmodule

// File: tb/test_sctl_port.sv
module test_sctl_port;

  logic        clk = 1'b0;
  logic        rst_n, host_mode, ser_clk, ser_dat, ser_lat;
  logic        pin_deemph_en, pin_rate_b1, pin_rate_b2, word_tick;
  logic [10:0] atten_target;
  logic [5:0]  test_bits;
  logic        rate_meas_mode, gain_boost, deemph_en, mute_req;
  logic [1:0]  deemph_fs;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sctl_port i_sctl_port (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .ser_lat(ser_lat), .pin_deemph_en(pin_deemph_en),
    .pin_rate_b1(pin_rate_b1), .pin_rate_b2(pin_rate_b2), .word_tick(word_tick),
    .atten_target(atten_target), .test_bits(test_bits), .rate_meas_mode(rate_meas_mode),
    .gain_boost(gain_boost), .deemph_en(deemph_en), .deemph_fs(deemph_fs),
    .mute_req(mute_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_dat = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
  endtask

  task automatic pulse_lat();
    ser_lat = 1'b1;
    wait_clk(6);
    ser_lat = 1'b0;
    wait_clk(4);
  endtask

  task automatic shift_word(input logic [11:0] f);
    for (int i = 11; i >= 0; i--) shift_bit(f[i]);
  endtask

  task automatic send_frame(input logic [11:0] f);
    shift_word(f);
    pulse_lat();
  endtask

  function automatic logic [11:0] mode_frame(input logic [5:0] t, input logic m,
                                             input logic g, input logic b1,
                                             input logic b2, input logic e);
    return {1'b1, t, m, g, b1, b2, e};
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      word_tick = 1'b1;
      wait_clk(1);
      word_tick = 1'b0;
      wait_clk(1);
    end
  endtask

  task automatic t_reset();
    chk("R1 atten", atten_target, 11'h400);
    chk("R1 test", test_bits, 0);
    chk("R1 meas", rate_meas_mode, 0);
    chk("R1 boost", gain_boost, 0);
    chk("R1 en", deemph_en, 0);
    chk("R1 fs", deemph_fs, 0);
    chk("R1 mute", mute_req, 0);
  endtask

  task automatic t_atten();
    send_frame({1'b0, 11'h155});
    chk("R2 atten", atten_target, 11'h155);
    chk("R2 flags boost", gain_boost, 0);
    chk("R2 flags fs", deemph_fs, 0);
    chk("R2 no mute", mute_req, 0);
  endtask

  task automatic t_mode();
    send_frame(mode_frame(6'b101001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1));
    chk("R3 test", test_bits, 6'h29);
    chk("R3 meas", rate_meas_mode, 1);
    chk("R3 boost", gain_boost, 1);
    chk("R3 en", deemph_en, 1);
    chk("R6 fs 48k", deemph_fs, 1);
    chk("R3 atten kept", atten_target, 11'h155);
    chk("R8 mute raised", mute_req, 1);
    ticks(3071);
    chk("R8 mute before last word", mute_req, 1);
    ticks(1);
    chk("R8 mute released", mute_req, 0);
  endtask

  task automatic t_decode();
    send_frame(mode_frame(6'b101001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1));
    chk("R6 fs 32k", deemph_fs, 2);
    chk("R8 mute on 32k", mute_req, 1);
    ticks(3072);
    chk("R8 mute cleared", mute_req, 0);
    send_frame(mode_frame(6'b101001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1));
    chk("R6 fs code 01", deemph_fs, 0);
    chk("R8 mute on 44k1", mute_req, 1);
    ticks(3072);
    send_frame(mode_frame(6'b101001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
    chk("R6 fs code 00", deemph_fs, 0);
    chk("R10 01 to 00 no mute", mute_req, 0);
    send_frame(mode_frame(6'b101001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
    chk("R10 en off", deemph_en, 0);
    chk("R10 en toggle no mute", mute_req, 0);
  endtask

  task automatic t_restart();
    send_frame(mode_frame(6'b101001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
    chk("R9 first change", mute_req, 1);
    ticks(1000);
    send_frame(mode_frame(6'b101001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
    chk("R9 fs", deemph_fs, 2);
    ticks(3071);
    chk("R9 still muted after restart", mute_req, 1);
    ticks(1);
    chk("R9 released", mute_req, 0);
  endtask

  task automatic t_extra_bits();
    shift_bit(1'b1);
    shift_bit(1'b1);
    shift_bit(1'b1);
    send_frame({1'b0, 11'h2C3});
    chk("R4 atten", atten_target, 11'h2C3);
    chk("R4 mode kept", deemph_fs, 2);
  endtask

  task automatic t_no_latch();
    shift_word({1'b0, 11'h07F});
    wait_clk(10);
    chk("R5 unchanged without latch", atten_target, 11'h2C3);
    pulse_lat();
    chk("R5 latch commits", atten_target, 11'h07F);
  endtask

  task automatic t_pins();
    pin_rate_b1   = 1'b1;
    pin_rate_b2   = 1'b0;
    pin_deemph_en = 1'b1;
    host_mode     = 1'b0;
    wait_clk(10);
    chk("R7 atten unity", atten_target, 11'h400);
    chk("R7 boost", gain_boost, 0);
    chk("R7 meas", rate_meas_mode, 0);
    chk("R7 test", test_bits, 0);
    chk("R7 en pin", deemph_en, 1);
    chk("R7 fs pin", deemph_fs, 1);
    chk("R8 pin rate mute", mute_req, 1);
    send_frame({1'b0, 11'h0AA});
    chk("R7 atten held unity", atten_target, 11'h400);
    host_mode = 1'b1;
    wait_clk(10);
    chk("R7 atten from frame", atten_target, 11'h0AA);
    chk("R7 boost back", gain_boost, 1);
    chk("R7 fs back", deemph_fs, 2);
    chk("R7 en back", deemph_en, 0);
  endtask

  initial begin
    rst_n = 1'b0; host_mode = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0; ser_lat = 1'b0;
    pin_deemph_en = 1'b0; pin_rate_b1 = 1'b0; pin_rate_b2 = 1'b0; word_tick = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(10);
    t_reset();
    t_atten();
    t_mode();
    t_decode();
    t_restart();
    t_extra_bits();
    t_no_latch();
    t_pins();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule